// File: doc/BRIEF.md
# Reset Line Controller with Completion Status

This block holds up to eight reset outputs for the sub-modules of one power domain. Software sets a bit in a control register to hold the matching line in reset and clears it to let the line go. Once a line has been let go, a per-line timer stands in for the sub-module's own reset sequence. When it expires, the block raises a completion bit in a status register. Software clears that bit by writing a one to it.

Each instance is shaped by parameters:
- which lines exist, through a valid-line mask;
- where each line reports in the status register, through a mapping that need not be the identity;
- the offsets of the two registers;
- whether a status register is present at all;
- whether the lines start out held in reset.

A `line_busy` output summarises whether each line still counts as in reset.

Top module: `rstline_ctl`

## Requirements
- R1: The control register sits at offset `CTRL_OFS`. Bit n drives `rst_out[n]`, and 1 means the line is held in reset. After reset the register holds `VALID_MASK` when `INIT_ASSERT` is 1 and holds 0 otherwise. The status register resets to 0.
- R2: A write to `CTRL_OFS` loads every valid bit from `reg_wdata`, so a read-modify-write leaves the other lines as they were. `rst_out` shows the new value in the cycle after the write edge. Any other address leaves the control register unchanged.
- R3: When `ctrl[n]` goes from 1 to 0 on a write edge, status bit `STAT_MAP[3n+2:3n]` becomes visible `DONE_DELAY` clock edges later. With the defaults, line n reports on bit n.
- R4: Writing to `STAT_OFS` clears each status bit whose `reg_wdata` bit is 1 and leaves bits written with 0 unchanged. A completion that arrives in the same cycle wins over the clear.
- R5: While `ctrl[n]` is 1, its mapped status bit is forced to 0 from the next edge on. Any completion still pending for that line is cancelled, and the count restarts from zero on the next release.
- R6: `line_busy[n]` is 1 for a valid line when `ctrl[n]` is 1, or when its mapped status bit is 0. With `HAS_STATUS` = 0 it follows `ctrl[n]` alone.
- R7: Bits for lines outside `VALID_MASK` always read 0 and ignore writes, in both registers. Status positions that no valid line maps to behave the same way. For such lines `rst_out` and `line_busy` stay 0.
- R8: `reg_rdata` is registered and returns, one edge later, the register selected by `reg_addr`. Unmapped addresses return 0, and so does `STAT_OFS` when `HAS_STATUS` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rst_out | output | 8 | Reset outputs, 1 = held in reset |
| line_busy | output | 8 | Per-line in-reset indication |

## Verification
The assertions take for granted that the parameters are consistent:
- no two valid lines share a status position;
- the two register offsets differ;
- `DONE_DELAY` is at least 1.

The bench keeps within these limits by building three fixed instances: an identity map, a swapped-and-shifted map, and a status-less one. Its random traffic picks addresses from the offsets those instances use, plus an occasional random offset. Writes come on about one cycle in four, so many releases run to completion and others are cut short by a re-assert.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int MAX_LINES = 8;
  localparam int IDX_W     = $clog2(MAX_LINES);
  localparam int MAP_W     = IDX_W * MAX_LINES;

  typedef logic [MAX_LINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0]     line_idx_t;

  localparam logic [MAP_W-1:0] IDENT_MAP =
    {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
endpackage

// File: rtl/rstc_line_timer.sv
module rstc_line_timer #(
  parameter int DONE_DELAY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic done_o
);
  localparam int CNT_W = (DONE_DELAY < 2) ? 1 : $clog2(DONE_DELAY);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DONE_DELAY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign done_o = pend_q && !hold && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (hold) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else if (pend_q) begin
      if (cnt_q == LAST) pend_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R3
endmodule

// File: rtl/rstc_status.sv
module rstc_status
  import rstc_pkg::*;
#(
  parameter line_vec_t         VALID_MASK = 8'h07,
  parameter logic [MAP_W-1:0]  STAT_MAP   = IDENT_MAP
) (
  input  logic      clk,
  input  logic      rst,
  input  line_vec_t hold,
  input  line_vec_t done,
  input  logic      clr_en,
  input  line_vec_t clr_bits,
  output line_vec_t stat_q,
  output line_vec_t line_stat
);
  line_vec_t set_v, force_v, used_v;

  always_comb begin
    set_v   = '0;
    force_v = '0;
    used_v  = '0;
    for (int i = 0; i < MAX_LINES; i++) begin
      if (VALID_MASK[i]) begin
        used_v[STAT_MAP[IDX_W*i +: IDX_W]] = 1'b1;
        if (done[i]) set_v[STAT_MAP[IDX_W*i +: IDX_W]]   = 1'b1;
        if (hold[i]) force_v[STAT_MAP[IDX_W*i +: IDX_W]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      for (int j = 0; j < MAX_LINES; j++) begin
        if (!used_v[j] || force_v[j])      stat_q[j] <= 1'b0;
        else if (set_v[j])                 stat_q[j] <= 1'b1;
        else if (clr_en && clr_bits[j])    stat_q[j] <= 1'b0;
      end
    end
  end

  always_comb begin
    line_stat = '0;
    for (int i = 0; i < MAX_LINES; i++)
      if (VALID_MASK[i]) line_stat[i] = stat_q[STAT_MAP[IDX_W*i +: IDX_W]];
  end

  for (genvar j = 0; j < MAX_LINES; j++) begin : g_w1c_chk
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (clr_en && clr_bits[j] && !set_v[j]) |=> !stat_q[j]); // R4
  end

  for (genvar i = 0; i < MAX_LINES; i++) begin : g_line_chk
    if (VALID_MASK[i]) begin : g_valid
      localparam int M = int'(STAT_MAP[IDX_W*i +: IDX_W]);
      AST_HOLD_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
        hold[i] |=> !stat_q[M]); // R5
      AST_RISE_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[M]) |-> $past(done[i])); // R3
    end
  end
endmodule

// File: rtl/rstline_ctl.sv
module rstline_ctl
  import rstc_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter line_vec_t         VALID_MASK  = 8'h07,
  parameter logic [MAP_W-1:0]  STAT_MAP    = IDENT_MAP,
  parameter int                CTRL_OFS    = 'h10,
  parameter int                STAT_OFS    = 'h14,
  parameter bit                HAS_STATUS  = 1'b1,
  parameter bit                INIT_ASSERT = 1'b1,
  parameter int                DONE_DELAY  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [MAX_LINES-1:0] reg_wdata,
  output logic [MAX_LINES-1:0] reg_rdata,
  output logic [MAX_LINES-1:0] rst_out,
  output logic [MAX_LINES-1:0] line_busy
);
  localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] STAT_A   = ADDR_W'(STAT_OFS);
  localparam line_vec_t         CTRL_RST = INIT_ASSERT ? VALID_MASK : '0;

  line_vec_t ctrl_q, stat_q, line_stat, done_v;
  logic      ctrl_hit, stat_hit;

  assign ctrl_hit = (reg_addr == CTRL_A);
  assign stat_hit = HAS_STATUS && (reg_addr == STAT_A);

  always_ff @(posedge clk) begin
    if (rst)                      ctrl_q <= CTRL_RST;
    else if (reg_wr && ctrl_hit)  ctrl_q <= reg_wdata & VALID_MASK;
  end

  for (genvar i = 0; i < MAX_LINES; i++) begin : g_line
    if (HAS_STATUS && VALID_MASK[i]) begin : g_timer
      rstc_line_timer #(.DONE_DELAY(DONE_DELAY)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .hold  (ctrl_q[i]),
        .done_o(done_v[i])
      );
    end else begin : g_none
      assign done_v[i] = 1'b0;
    end
  end

  if (HAS_STATUS) begin : g_status
    rstc_status #(.VALID_MASK(VALID_MASK), .STAT_MAP(STAT_MAP)) u_status (
      .clk      (clk),
      .rst      (rst),
      .hold     (ctrl_q),
      .done     (done_v),
      .clr_en   (reg_wr && stat_hit),
      .clr_bits (reg_wdata),
      .stat_q   (stat_q),
      .line_stat(line_stat)
    );
    assign line_busy = VALID_MASK & (ctrl_q | ~line_stat);
  end else begin : g_no_status
    assign stat_q    = '0;
    assign line_stat = '0;
    assign line_busy = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst)           reg_rdata <= '0;
    else if (ctrl_hit) reg_rdata <= ctrl_q;
    else if (stat_hit) reg_rdata <= stat_q;
    else               reg_rdata <= '0;
  end

  assign rst_out = ctrl_q;

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && ctrl_hit) |=> rst_out == ($past(reg_wdata) & VALID_MASK)); // R2
  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && ctrl_hit) |=> $stable(rst_out)); // R2
endmodule

// File: tb/rstline_ctl_tb_top.sv
module rstline_ctl_model #(
  parameter logic [7:0]  VALID_MASK  = 8'h07,
  parameter logic [23:0] STAT_MAP    = 24'h0,
  parameter int          CTRL_OFS    = 'h10,
  parameter int          STAT_OFS    = 'h14,
  parameter bit          HAS_STATUS  = 1'b1,
  parameter bit          INIT_ASSERT = 1'b1,
  parameter int          DONE_DELAY  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] e_rst,
  output logic [7:0] e_busy,
  output logic [7:0] e_rdata
);
  logic [7:0] ctrl, stat, armed;
  int         age [8];

  always @(posedge clk) begin
    logic [7:0] nstat, fin;
    if (rst) begin
      ctrl = INIT_ASSERT ? VALID_MASK : 8'h00;
      stat = 8'h00; armed = 8'h00; e_rdata = 8'h00;
      for (int i = 0; i < 8; i++) age[i] = 0;
    end else begin
      for (int i = 0; i < 8; i++)
        fin[i] = HAS_STATUS && VALID_MASK[i] && armed[i] && !ctrl[i] &&
                 (age[i] == DONE_DELAY - 1);
      nstat = stat;
      if (wr && addr == 8'(STAT_OFS)) nstat = nstat & ~wdata;
      for (int i = 0; i < 8; i++) begin
        if (VALID_MASK[i]) begin
          if (fin[i])  nstat[STAT_MAP[3*i +: 3]] = 1'b1;
          if (ctrl[i]) nstat[STAT_MAP[3*i +: 3]] = 1'b0;
        end
      end
      if (addr == 8'(CTRL_OFS))                    e_rdata = ctrl;
      else if (HAS_STATUS && addr == 8'(STAT_OFS)) e_rdata = stat;
      else                                         e_rdata = 8'h00;
      for (int i = 0; i < 8; i++) begin
        if (ctrl[i]) begin age[i] = 0; armed[i] = 1'b1; end
        else if (armed[i]) begin
          if (age[i] == DONE_DELAY - 1) armed[i] = 1'b0;
          else age[i] = age[i] + 1;
        end
      end
      if (HAS_STATUS) stat = nstat;
      if (wr && addr == 8'(CTRL_OFS)) ctrl = wdata & VALID_MASK;
    end
  end

  always_comb begin
    e_rst = ctrl;
    for (int i = 0; i < 8; i++)
      e_busy[i] = VALID_MASK[i] &&
                  (ctrl[i] || (HAS_STATUS && !stat[STAT_MAP[3*i +: 3]]));
  end
endmodule

module rstline_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] MAP_A = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [23:0] MAP_B = {3'd7, 3'd6, 3'd5, 3'd4, 3'd5, 3'd2, 3'd0, 3'd1};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] a_rd, a_rst, a_busy, b_rd, b_rst, b_busy, c_rd, c_rst, c_busy;
  logic [7:0] ea_rd, ea_rst, ea_busy, eb_rd, eb_rst, eb_busy, ec_rd, ec_rst, ec_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstline_ctl dut_i (
    .clk(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(a_rd), .rst_out(a_rst), .line_busy(a_busy));
  rstline_ctl #(.VALID_MASK(8'h0B), .STAT_MAP(MAP_B), .CTRL_OFS('h0),
    .STAT_OFS('h4), .INIT_ASSERT(1'b0), .DONE_DELAY(2)) dut_b_i (
    .clk(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(b_rd), .rst_out(b_rst), .line_busy(b_busy));
  rstline_ctl #(.VALID_MASK(8'h01), .CTRL_OFS('h0), .STAT_OFS('h4),
    .HAS_STATUS(1'b0), .INIT_ASSERT(1'b0), .DONE_DELAY(3)) dut_c_i (
    .clk(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(c_rd), .rst_out(c_rst), .line_busy(c_busy));

  rstline_ctl_model #(.VALID_MASK(8'h07), .STAT_MAP(MAP_A)) mdl_a (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wdata(wdata),
    .e_rst(ea_rst), .e_busy(ea_busy), .e_rdata(ea_rd));
  rstline_ctl_model #(.VALID_MASK(8'h0B), .STAT_MAP(MAP_B), .CTRL_OFS('h0),
    .STAT_OFS('h4), .INIT_ASSERT(1'b0), .DONE_DELAY(2)) mdl_b (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wdata(wdata),
    .e_rst(eb_rst), .e_busy(eb_busy), .e_rdata(eb_rd));
  rstline_ctl_model #(.VALID_MASK(8'h01), .STAT_MAP(MAP_A), .CTRL_OFS('h0),
    .STAT_OFS('h4), .HAS_STATUS(1'b0), .INIT_ASSERT(1'b0), .DONE_DELAY(3)) mdl_c (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wdata(wdata),
    .e_rst(ec_rst), .e_busy(ec_busy), .e_rdata(ec_rd));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the bench model
  always @(negedge clk) begin
    if (!rst) begin
      check("R1 rst_out inst A", a_rst, ea_rst);
      check("R6 line_busy inst A", a_busy, ea_busy);
      check("R8 rdata inst A", a_rd, ea_rd);
      check("R1 rst_out inst B", b_rst, eb_rst);
      check("R6 line_busy inst B", b_busy, eb_busy);
      check("R8 rdata inst B", b_rd, eb_rd);
      check("R7 rst_out inst C", c_rst, ec_rst);
      check("R6 line_busy inst C", c_busy, ec_busy);
      check("R8 rdata inst C", c_rd, ec_rd);
    end
  end

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_set(logic [7:0] a);
    @(negedge clk); wr = 1'b0; addr = a;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    int seed;
    logic [7:0] pick [5];
    seed = $urandom(32'd20240517);
    pick[0] = 8'h00; pick[1] = 8'h04; pick[2] = 8'h10; pick[3] = 8'h14;
    addr = 8'h40;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset values
    check("R1 init ctrl inst A", a_rst, 8'h07);
    check("R1 init ctrl inst B", b_rst, 8'h00);
    check("R6 busy after reset inst B", b_busy, 8'h0B);
    rd_set(8'h14);
    check("R1 status reset value inst A", a_rd, 8'h00);

    // R3 release of all lines in inst A, identity map
    wr_reg(8'h10, 8'h00);
    check("R3 not complete right after release inst A", a_busy, 8'h07);
    idle(6);
    rd_set(8'h14);
    check("R3 status set after delay inst A", a_rd, 8'h07);
    check("R6 busy clear after completion inst A", a_busy, 8'h00);

    // R3 remapped status positions in inst B
    wr_reg(8'h00, 8'h0B);
    wr_reg(8'h00, 8'h00);
    idle(4);
    rd_set(8'h04);
    check("R3 remapped status inst B", b_rd, 8'h23);
    check("R7 status-less read inst C", c_rd, 8'h00);

    // R4 write-one-to-clear
    wr_reg(8'h14, 8'h02);
    rd_set(8'h14);
    check("R4 w1c clears only bit 1", a_rd, 8'h05);
    wr_reg(8'h14, 8'h00);
    rd_set(8'h14);
    check("R4 writing 0 keeps status", a_rd, 8'h05);

    // R5 re-assert before completion cancels it
    wr_reg(8'h10, 8'h01);
    wr_reg(8'h10, 8'h00);
    wr_reg(8'h10, 8'h01);
    wr_reg(8'h10, 8'h00);
    rd_set(8'h14);
    check("R5 bit 0 stays low after cancel", a_rd, 8'h04);
    idle(6);
    rd_set(8'h14);
    check("R5 completion after final release", a_rd, 8'h05);

    // R7 bits outside the valid mask
    wr_reg(8'h10, 8'hFF);
    check("R7 rst_out masked inst A", a_rst, 8'h07);
    rd_set(8'h10);
    check("R7 ctrl readback masked inst A", a_rd, 8'h07);
    wr_reg(8'h00, 8'hFF);
    check("R7 rst_out masked inst B", b_rst, 8'h0B);
    check("R2 other instance unchanged", a_rst, 8'h07);

    // random traffic, checked every cycle against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      pick[4] = 8'($urandom);
      wr    = ($urandom % 4) == 0;
      addr  = pick[$urandom % 5];
      wdata = 8'($urandom);
    end
    @(negedge clk); wr = 1'b0;
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R8 actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule